// File: doc/BRIEF.md
# Memory Size Probe Engine

This engine works out how much usable RAM answers behind a word-wide synchronous memory port. After a start pulse it walks a series of byte offsets from word address zero, where the first offset is 1 MiB and each later one is twice the one before. At each offset it plants a marker and watches for the two ways a missing region shows itself: the write lands back on the base word (address aliasing), or the marker does not read back (no memory there).

Every word it touches is read and saved before the test writes and written back afterwards, so the memory holds the same data when the engine finishes. The result is a byte count, reported together with a one-cycle done pulse. It is meant to run once during bring-up, before any other agent uses the memory.

Top module: `msp_size_probe`

## Requirements
- R1: While reset is high, and until the first accepted start, `busy`, `done`, `mem_re` and `mem_we` are 0 and `size_bytes` is 0.
- R2: Every memory access goes to word address 0 (the base) or to a probe word address. A probe word address is the probe byte offset divided by 4. The first probe offset is 1 MiB, which is word 0x40000, and each following offset is twice the previous one.
- R3: In each probe step the writes come in this order: the word index (the offset divided by 4, which equals the probe word address) to the probe word, then 0 to the base, then the saved probe word, then the saved base word.
- R4: At most one read is in flight. No new read or write is issued until `mem_rvalid` has returned for the last read. `mem_re` and `mem_we` are never high together, and neither is high while the engine is idle.
- R5: If the probe word does not read back its word index, the result is that step's byte offset. When this happens at the first 1 MiB probe, the result is 0.
- R6: If every probe offset below `max_bytes` passes, the result is `max_bytes`. When `max_bytes` is at most 1 MiB, the result is `max_bytes` and no memory access is made.
- R7: If the base word reads back nonzero after 0 has been written to it, both saved words are restored and the result is 0.
- R8: When a run ends, the base word and every probe word that physically exists hold the values they held before the run.
- R9: A start pulse during a run is ignored. The run finishes with the result for the `max_bytes` that was sampled when the run was accepted, and no second run follows.
- R10: `done` is high for exactly one cycle per run. `size_bytes` is cleared to 0 when a start is accepted, takes the result in the cycle `done` is high, and then holds.
- R11: The probe word is read twice after the marker is written, and only the second read is compared, so a wrong first read does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| max_bytes | input | 32 | Largest size to search, a power of two in bytes |
| mem_addr | output | 30 | Word address of the current access |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read request |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read completion, one or more cycles after mem_re |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| size_bytes | output | 32 | Detected size in bytes |

## Verification
The bench memory model takes several shapes. A fully populated array larger than the search range gives the full-size answer. Arrays that wrap their address at 1, 4 and larger powers of two separate the aliasing result from the zero result of a first-step failure. Arrays with a hole above 512 KiB or 2 MiB show that missing memory is caught by readback rather than by aliasing. A base word stuck at a nonzero value exercises the early restore and the zero result. A model whose first read after a write returns inverted data is passed only by a design that compares the second read. Read latency rotates from one to four cycles throughout, and preloaded per-address patterns show that contents are restored.

// File: rtl/msp_pkg.sv
package msp_pkg;

    localparam int WORD_W  = 32;
    localparam int LANE_SH = $clog2(WORD_W / 8);
    localparam int WADDR_W = WORD_W - LANE_SH;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [WADDR_W-1:0] waddr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_DECIDE
    } fsm_e;

    // Order of the accesses inside one probe step.
    typedef enum logic [3:0] {
        PH_SAVE_PROBE,
        PH_SAVE_BASE,
        PH_MARK_PROBE,
        PH_CLEAR_BASE,
        PH_CHECK_BASE,
        PH_FLUSH_PROBE,
        PH_SAMPLE_PROBE,
        PH_RESTORE_PROBE,
        PH_RESTORE_BASE
    } phase_e;

    typedef struct packed {
        logic rd;
        logic at_probe;
    } access_t;

    function automatic access_t access_of(input phase_e ph);
        access_t a;
        a.rd       = (ph inside {PH_SAVE_PROBE, PH_SAVE_BASE, PH_CHECK_BASE,
                                 PH_FLUSH_PROBE, PH_SAMPLE_PROBE});
        a.at_probe = (ph inside {PH_SAVE_PROBE, PH_MARK_PROBE, PH_FLUSH_PROBE,
                                 PH_SAMPLE_PROBE, PH_RESTORE_PROBE});
        return a;
    endfunction

    function automatic phase_e step_after(input phase_e ph);
        case (ph)
            PH_SAVE_PROBE:    return PH_SAVE_BASE;
            PH_SAVE_BASE:     return PH_MARK_PROBE;
            PH_MARK_PROBE:    return PH_CLEAR_BASE;
            PH_CLEAR_BASE:    return PH_CHECK_BASE;
            PH_CHECK_BASE:    return PH_FLUSH_PROBE;
            PH_FLUSH_PROBE:   return PH_SAMPLE_PROBE;
            PH_SAMPLE_PROBE:  return PH_RESTORE_PROBE;
            PH_RESTORE_PROBE: return PH_RESTORE_BASE;
            default:          return PH_SAVE_PROBE;
        endcase
    endfunction

endpackage

// File: rtl/msp_offset_walk.sv
module msp_offset_walk
    import msp_pkg::*;
#(
    parameter word_t FIRST_BYTES = 32'h0010_0000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   advance,
    input  word_t  limit_in,
    output word_t  offset_bytes,
    output waddr_t probe_word,
    output word_t  limit_bytes,
    output logic   is_first,
    output logic   reached
);

    word_t offset_q;
    word_t limit_q;
    logic  first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            limit_q  <= '0;
            first_q  <= 1'b0;
        end else if (load) begin
            offset_q <= FIRST_BYTES;
            limit_q  <= limit_in;
            first_q  <= 1'b1;
        end else if (advance) begin
            offset_q <= offset_q << 1;
            first_q  <= 1'b0;
        end
    end

    assign offset_bytes = offset_q;
    assign probe_word   = offset_q[WORD_W-1:LANE_SH];
    assign limit_bytes  = limit_q;
    assign is_first     = first_q;
    assign reached      = (offset_q >= limit_q);

endmodule

// File: rtl/msp_capture.sv
module msp_capture
    import msp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step_clr,
    input  logic   rd_done,
    input  phase_e phase,
    input  word_t  rdata,
    input  word_t  expect_val,
    output word_t  save_probe,
    output word_t  save_base,
    output logic   base_hit,
    output logic   base_dirty,
    output logic   mismatch
);

    assign base_hit = (rdata != '0);

    always_ff @(posedge clk) begin
        if (rst || step_clr) begin
            save_probe <= '0;
            save_base  <= '0;
            base_dirty <= 1'b0;
            mismatch   <= 1'b0;
        end else if (rd_done) begin
            case (phase)
                PH_SAVE_PROBE:   save_probe <= rdata;
                PH_SAVE_BASE:    save_base  <= rdata;
                PH_CHECK_BASE:   base_dirty <= base_hit;
                PH_SAMPLE_PROBE: mismatch   <= (rdata != expect_val);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msp_ctrl.sv
module msp_ctrl
    import msp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   reached,
    input  logic   is_first,
    input  word_t  offset_bytes,
    input  word_t  limit_bytes,
    input  waddr_t probe_word,
    input  logic   mem_rvalid,
    input  logic   base_hit,
    input  logic   base_dirty,
    input  logic   mismatch,
    input  word_t  save_probe,
    input  word_t  save_base,
    output logic   load,
    output logic   advance,
    output logic   step_clr,
    output logic   rd_done,
    output phase_e phase,
    output word_t  expect_val,
    output waddr_t mem_addr,
    output word_t  mem_wdata,
    output logic   mem_we,
    output logic   mem_re,
    output logic   busy,
    output logic   done,
    output word_t  size_bytes
);

    fsm_e    state;
    access_t acc;

    assign acc        = access_of(phase);
    assign expect_val = {{LANE_SH{1'b0}}, probe_word};

    assign load     = (state == ST_IDLE) && start;
    assign step_clr = (state == ST_CHECK) && !reached;
    assign rd_done  = (state == ST_WAIT) && mem_rvalid;
    assign advance  = (state == ST_DECIDE) && !base_dirty && !mismatch;
    assign busy     = (state != ST_IDLE);

    assign mem_re   = (state == ST_ISSUE) && acc.rd;
    assign mem_we   = (state == ST_ISSUE) && !acc.rd;
    assign mem_addr = acc.at_probe ? probe_word : '0;

    always_comb begin
        case (phase)
            PH_MARK_PROBE:    mem_wdata = expect_val;
            PH_RESTORE_PROBE: mem_wdata = save_probe;
            PH_RESTORE_BASE:  mem_wdata = save_base;
            default:          mem_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            phase      <= PH_SAVE_PROBE;
            done       <= 1'b0;
            size_bytes <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state      <= ST_CHECK;
                        size_bytes <= '0;
                    end
                end
                ST_CHECK: begin
                    if (reached) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        size_bytes <= limit_bytes;
                    end else begin
                        state <= ST_ISSUE;
                        phase <= PH_SAVE_PROBE;
                    end
                end
                ST_ISSUE: begin
                    if (acc.rd) begin
                        state <= ST_WAIT;
                    end else if (phase == PH_RESTORE_BASE) begin
                        state <= ST_DECIDE;
                    end else begin
                        phase <= step_after(phase);
                    end
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        state <= ST_ISSUE;
                        if ((phase == PH_CHECK_BASE) && base_hit) begin
                            phase <= PH_RESTORE_PROBE;
                        end else begin
                            phase <= step_after(phase);
                        end
                    end
                end
                ST_DECIDE: begin
                    if (base_dirty) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        size_bytes <= '0;
                    end else if (mismatch) begin
                        state      <= ST_IDLE;
                        done       <= 1'b1;
                        size_bytes <= is_first ? '0 : offset_bytes;
                    end else begin
                        state <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msp_size_probe.sv
module msp_size_probe
    import msp_pkg::*;
#(
    parameter word_t FIRST_BYTES = 32'h0010_0000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [31:0]  max_bytes,
    output logic [29:0]  mem_addr,
    output logic [31:0]  mem_wdata,
    output logic         mem_we,
    output logic         mem_re,
    input  logic [31:0]  mem_rdata,
    input  logic         mem_rvalid,
    output logic         busy,
    output logic         done,
    output logic [31:0]  size_bytes
);

    logic   load, advance, step_clr, rd_done;
    logic   reached, is_first;
    word_t  offset_bytes, limit_bytes, expect_val;
    waddr_t probe_word;
    phase_e phase;
    logic   base_hit, base_dirty, mismatch;
    word_t  save_probe, save_base;

    msp_offset_walk #(.FIRST_BYTES(FIRST_BYTES)) u_walk (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .advance      (advance),
        .limit_in     (max_bytes),
        .offset_bytes (offset_bytes),
        .probe_word   (probe_word),
        .limit_bytes  (limit_bytes),
        .is_first     (is_first),
        .reached      (reached)
    );

    msp_capture u_capture (
        .clk        (clk),
        .rst        (rst),
        .step_clr   (step_clr),
        .rd_done    (rd_done),
        .phase      (phase),
        .rdata      (mem_rdata),
        .expect_val (expect_val),
        .save_probe (save_probe),
        .save_base  (save_base),
        .base_hit   (base_hit),
        .base_dirty (base_dirty),
        .mismatch   (mismatch)
    );

    msp_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .reached      (reached),
        .is_first     (is_first),
        .offset_bytes (offset_bytes),
        .limit_bytes  (limit_bytes),
        .probe_word   (probe_word),
        .mem_rvalid   (mem_rvalid),
        .base_hit     (base_hit),
        .base_dirty   (base_dirty),
        .mismatch     (mismatch),
        .save_probe   (save_probe),
        .save_base    (save_base),
        .load         (load),
        .advance      (advance),
        .step_clr     (step_clr),
        .rd_done      (rd_done),
        .phase        (phase),
        .expect_val   (expect_val),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .busy         (busy),
        .done         (done),
        .size_bytes   (size_bytes)
    );

endmodule

// File: rtl/msp_probe_checks.sv
module msp_probe_checks (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        mem_re,
    input logic        mem_we,
    input logic        mem_rvalid,
    input logic [31:0] size_bytes
);

    logic in_flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= 1'b0;
        end else if (mem_re) begin
            in_flight <= 1'b1;
        end else if (mem_rvalid) begin
            in_flight <= 1'b0;
        end
    end

    assert_one_read_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> !in_flight);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_re || mem_we));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_size_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(size_bytes));

    assert_size_shape_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0(size_bytes));

    assert_run_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

endmodule

bind msp_size_probe msp_probe_checks u_checks (.*);

// File: tb/msp_size_probe_bench.sv
module msp_size_probe_bench;

    localparam int unsigned FIRST   = 32'h0010_0000;
    localparam int unsigned FIRST_W = FIRST / 4;
    localparam int unsigned MIB     = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] max_bytes = '0;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we, mem_re;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        busy, done;
    logic [31:0] size_bytes;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    msp_size_probe u_msp_size_probe (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .max_bytes  (max_bytes),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid),
        .busy       (busy),
        .done       (done),
        .size_bytes (size_bytes)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [31:0] store [int unsigned];
    bit          fresh [int unsigned];
    int unsigned phys_words = 1;
    bit hole_mode = 0, stuck_mode = 0, flaky_mode = 0;

    function automatic logic [31:0] seed_val(input int unsigned w);
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic bit absent(input int unsigned w);
        return hole_mode && (w >= phys_words);
    endfunction

    function automatic int unsigned home(input int unsigned w);
        return hole_mode ? w : (w % phys_words);
    endfunction

    function automatic logic [31:0] fetch(input int unsigned w, input bit consume);
        int unsigned k;
        logic [31:0] v;
        if (stuck_mode && w == 0) return 32'hBAD0_0001;
        if (absent(w)) return 32'hFFFF_FFFF;
        k = home(w);
        v = store.exists(k) ? store[k] : seed_val(k);
        if (consume && flaky_mode && fresh.exists(k) && fresh[k]) begin
            fresh[k] = 1'b0;
            return ~v;
        end
        return v;
    endfunction

    function automatic void put(input int unsigned w, input logic [31:0] d);
        int unsigned k;
        if (stuck_mode && w == 0) return;
        if (absent(w)) return;
        k = home(w);
        store[k] = d;
        if (w != 0) fresh[k] = 1'b1;
    endfunction

    int unsigned rd_left = 0, rd_word = 0, rd_seq = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_left != 0) begin
            rd_left = rd_left - 1;
            if (rd_left == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= fetch(rd_word, 1'b1);
            end
        end
        if (!rst && mem_re) begin
            rd_word = int'(mem_addr);
            rd_seq  = rd_seq + 1;
            rd_left = 1 + (rd_seq % 4);
        end
        if (!rst && mem_we) put(int'(mem_addr), mem_wdata);
    end

    // ---------------- per-clock reference comparisons ----------------
    bit          outstanding = 0;
    int          writes_in_run = 0;
    int          accesses_in_run = 0;
    bit          saw_probe = 0;
    int unsigned first_probe = 0;
    longint      cur_max = 0;

    always @(negedge clk) begin
        if (!rst) begin
            int unsigned a;
            a = int'(mem_addr);
            check(!(mem_re && mem_we), "R4", "read and write together", 1, 0);
            check(!((mem_re || mem_we) && outstanding), "R4", "access while read in flight", 1, 0);
            check(busy || !(mem_re || mem_we), "R4", "access while idle", 1, 0);
            if (mem_rvalid) outstanding = 1'b0;
            if (mem_re) outstanding = 1'b1;
            if (mem_re || mem_we) begin
                accesses_in_run++;
                check((a == 0) || ($countones(a) == 1 && a >= FIRST_W && longint'(a) * 4 < cur_max),
                      "R2", "access word address", a, 0);
                if (a != 0 && !saw_probe) begin
                    saw_probe   = 1'b1;
                    first_probe = a;
                end
            end
            if (mem_we) begin
                case (writes_in_run % 4)
                    0: check(a != 0 && mem_wdata == a, "R3", "marker write data", mem_wdata, a);
                    1: check(a == 0 && mem_wdata == 0, "R3", "base clear write", {a, mem_wdata}, 0);
                    2: check(a != 0, "R3", "probe restore address", a, 1);
                    default: check(a == 0, "R3", "base restore address", a, 0);
                endcase
                writes_in_run++;
            end
        end
    end

    // ---------------- expectations from the requirements ----------------
    function automatic longint predict(input longint mx, input longint phys, input bit stuck);
        longint off;
        off = FIRST;
        if (off >= mx) return mx;             // R6
        if (stuck) return 0;                  // R7
        while (off < mx) begin
            if (off >= phys) return (off == FIRST) ? 0 : off;   // R5
            off = off * 2;
        end
        return mx;                            // R6
    endfunction

    task automatic run_case(input string req, input longint mx, input longint phys,
                            input bit hole, input bit stuck, input bit flaky, input bit poke);
        longint exp;
        int     cyc;
        store.delete();
        fresh.delete();
        phys_words = int'(phys / 4);
        hole_mode  = hole;
        stuck_mode = stuck;
        flaky_mode = flaky;
        exp = predict(mx, phys, stuck);
        cur_max = mx;
        writes_in_run = 0;
        accesses_in_run = 0;
        saw_probe = 1'b0;
        first_probe = 0;
        @(negedge clk);
        max_bytes = mx[31:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        max_bytes = 32'h0000_0400;
        check(size_bytes == 0 || done, "R10", "size cleared at start", size_bytes, 0);
        cyc = 0;
        while (!done && cyc < 20000) begin
            if (poke && cyc == 15) begin
                start = 1'b1;
                max_bytes = 32'h0020_0000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc < 20000, req, "run timeout", cyc, 0);
        check(size_bytes == exp[31:0], req, "detected size", size_bytes, exp);
        check(!busy, "R10", "busy low with done", busy, 0);
        @(negedge clk);
        check(!done, "R10", "done is one cycle", done, 0);
        repeat (6) @(negedge clk);
        check(size_bytes == exp[31:0], "R10", "size holds", size_bytes, exp);
        check(!busy, "R9", "no second run", busy, 0);
        if (mx <= FIRST) begin
            check(accesses_in_run == 0, "R6", "no access below first probe", accesses_in_run, 0);
        end else begin
            check(saw_probe && first_probe == FIRST_W, "R2", "first probe word", first_probe, FIRST_W);
        end
        if (!stuck) begin
            check(fetch(0, 1'b0) == seed_val(0), "R8", "base word kept", fetch(0, 1'b0), seed_val(0));
            for (longint off = FIRST; off < mx; off = off * 2) begin
                int unsigned w;
                w = int'(off / 4);
                if (!absent(w))
                    check(fetch(w, 1'b0) == seed_val(home(w)), "R8", "probe word kept",
                          fetch(w, 1'b0), seed_val(home(w)));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_re && !mem_we && size_bytes == 0, "R1", "reset state",
              {busy, done, mem_re, mem_we}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!busy && !done && size_bytes == 0, "R1", "idle after reset", {busy, done, size_bytes}, 0);

        run_case("R6", 16 * MIB, 64 * MIB, 0, 0, 0, 0);
        run_case("R5", 16 * MIB, 4 * MIB, 0, 0, 0, 0);
        run_case("R5", 16 * MIB, 1 * MIB, 0, 0, 0, 0);
        run_case("R5", 16 * MIB, 2 * MIB, 1, 0, 0, 0);
        run_case("R5", 8 * MIB, MIB / 2, 1, 0, 0, 0);
        run_case("R7", 16 * MIB, 64 * MIB, 0, 1, 0, 0);
        run_case("R6", 1 * MIB, 64 * MIB, 0, 0, 0, 0);
        run_case("R6", 2 * MIB, 64 * MIB, 0, 0, 0, 0);
        run_case("R6", 256 * MIB, 256 * MIB, 0, 0, 0, 0);
        run_case("R11", 8 * MIB, 32 * MIB, 0, 0, 1, 0);
        run_case("R9", 16 * MIB, 8 * MIB, 0, 0, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        vectors++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule